// File: doc/BRIEF.md
# Configurable Two-Level Logic Array

This block is a sum-of-products fabric whose planes are loaded at run time. It has `N_IN` inputs, `N_TERM` product terms and `N_OUT` outputs. An AND plane builds each product term from true or complemented input literals. An OR plane then combines the product terms into the outputs.

A mode register chooses how the OR plane works:
- **PLA mode:** both planes are freely configurable.
- **PAL mode:** every output is wired to a fixed, dedicated group of terms, so the OR-plane registers are ignored.
- **ROM mode:** the AND plane is replaced by a full decode of all `2^N_IN` minterms, and each output reads one bit of its own stored truth-table word.

Each output can be taken straight from the array or from a flip-flop.

Configuration is written as 16-bit words through a single write port (`cfg_we`, `cfg_addr`, `cfg_wdata`). A small controller tracks whether the loaded configuration is complete. It has three states:
- **CFG_EMPTY:** entered at reset.
- **CFG_LOADING:** entered on any mapped configuration write.
- **CFG_READY:** entered on a write to the commit address.

The transitions are:
- EMPTY→LOADING on a configuration write.
- EMPTY→READY on a commit.
- LOADING→READY on a commit.
- READY→LOADING on a configuration write.
- READY→READY on a repeated commit.

Every other cycle holds the state. `cfg_valid` is high only in CFG_READY, and the outputs are forced low whenever it is low.

Top module: `sop_array`

## Requirements
- R1: After a synchronous active-high reset, `cfg_valid` is 0, `y_out` is 0, all plane words and the register-select field are 0, and the mode is PLA.
- R2: While `cfg_valid` is 0, `y_out` is all zeros whatever `x_in` is.
- R3: State changes take effect at the clock edge of the write:
  - A write to address 0xFF (commit) sets `cfg_valid` to 1 from the next cycle.
  - A write to any mapped configuration address clears it from the next cycle.
  - Without a write, `cfg_valid` keeps its value.
- R4: Term t is loaded at address t, using bits [2*N_IN-1:0]. The field at bits [2i+1:2i] controls input i:
  - 00: input i is ignored.
  - 01: the term requires `x_in[i]`=1.
  - 10: the term requires `x_in[i]`=0.
  - 11: the term is forced false.
  
  A term whose fields are all 00 is 1.
- R5: In PLA mode (mode code 0), output o is the OR of the terms whose bit t is set in the word at address 0x40+o. An output with no bits set is 0.
- R6: In PAL mode (mode code 1), output o is the OR of the terms t with floor(t/G)==o, where G=ceil(N_TERM/N_OUT). The OR-plane words are ignored. With the default geometry the groups are: output 0 gets terms 0–1, output 1 gets terms 2–3, output 2 gets terms 4–5, and output 3 is always 0.
- R7: In ROM mode (mode code 2), output o equals bit `x_in` of a 2^N_IN-bit word. Address 0x80+o*C+k, with C=2^N_IN/16, holds bits 16k..16k+15 of that word. The AND plane has no effect in this mode.
- R8: The mode is written at address 0xC0 through bits [1:0]. Code 3 is stored as PLA.
- R9: Bit o of the word at address 0xC1 selects the output path for output o:
  - When the bit is 1, `y_out[o]` shows the value the combinational path had one clock earlier.
  - When the bit is 0, `y_out[o]` follows the array in the same cycle.
- R10: Writes to unmapped addresses, and cycles with `cfg_we` low, change neither the configuration nor `cfg_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration word address |
| cfg_wdata | input | 16 | Configuration write data |
| x_in | input | N_IN | Array inputs |
| y_out | output | N_OUT | Array outputs |
| cfg_valid | output | 1 | Configuration committed and outputs meaningful |

## Verification
A configuration write changes the planes, and `cfg_valid`, at the rising edge that captures it. Combinational outputs then respond to `x_in` within the same cycle, and registered outputs one rising edge later. The bench drives all inputs at the falling edge and samples 1 ns later, which is after the write edge that precedes it. For registered outputs it holds one input value across a rising edge, changes it, and expects the registered bits to still show the earlier value while the combinational bits already show the new one. Expected values come from a bench-side model that decodes every write by the address map given in the requirements.

// File: rtl/sop_array_pkg.sv
package sop_array_pkg;

    localparam int ADDR_W = 8;

    // address map
    localparam int AND_BASE    = 'h00;
    localparam int OR_BASE     = 'h40;
    localparam int ROM_BASE    = 'h80;
    localparam int MODE_ADDR   = 'hC0;
    localparam int RSEL_ADDR   = 'hC1;
    localparam int COMMIT_ADDR = 'hFF;

    typedef enum logic [1:0] {
        MODE_PLA = 2'd0,
        MODE_PAL = 2'd1,
        MODE_ROM = 2'd2
    } plane_mode_e;

    typedef enum logic [1:0] {
        CFG_EMPTY   = 2'd0,
        CFG_LOADING = 2'd1,
        CFG_READY   = 2'd2
    } cfg_state_e;

endpackage

// File: rtl/sop_cfg_regs.sv
module sop_cfg_regs
    import sop_array_pkg::*;
#(
    parameter int N_IN   = 6,
    parameter int N_TERM = 6,
    parameter int N_OUT  = 4,
    parameter int DATA_W = 16
) (
    input  logic                                    clk,
    input  logic                                    rst,
    input  logic                                    we,
    input  logic [ADDR_W-1:0]                       addr,
    input  logic [DATA_W-1:0]                       wdata,
    output logic [N_TERM-1:0][2*N_IN-1:0]           and_cfg,
    output logic [N_OUT-1:0][N_TERM-1:0]            or_cfg,
    output logic [N_OUT-1:0][(1<<N_IN)-1:0]         rom_cfg,
    output plane_mode_e                             mode,
    output logic [N_OUT-1:0]                        reg_sel,
    output logic                                    valid
);

    localparam int CHUNKS = (1 << N_IN) / DATA_W;

    cfg_state_e state_q, state_d;

    logic hit_and, hit_or, hit_rom, hit_mode, hit_rsel, hit_commit, hit_cfg;

    // address decode
    always_comb begin
        hit_and = 1'b0;
        hit_or  = 1'b0;
        hit_rom = 1'b0;
        for (int t = 0; t < N_TERM; t++) begin
            if (int'(addr) == AND_BASE + t) hit_and = 1'b1;
        end
        for (int o = 0; o < N_OUT; o++) begin
            if (int'(addr) == OR_BASE + o) hit_or = 1'b1;
            for (int k = 0; k < CHUNKS; k++) begin
                if (int'(addr) == ROM_BASE + o*CHUNKS + k) hit_rom = 1'b1;
            end
        end
        hit_mode   = (int'(addr) == MODE_ADDR);
        hit_rsel   = (int'(addr) == RSEL_ADDR);
        hit_commit = (int'(addr) == COMMIT_ADDR);
        hit_cfg    = hit_and | hit_or | hit_rom | hit_mode | hit_rsel;
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= CFG_EMPTY;
        else     state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (we) begin
            unique case (state_q)
                CFG_EMPTY: begin
                    if (hit_commit)   state_d = CFG_READY;
                    else if (hit_cfg) state_d = CFG_LOADING;
                end
                CFG_LOADING: begin
                    if (hit_commit)   state_d = CFG_READY;
                end
                CFG_READY: begin
                    if (hit_cfg)      state_d = CFG_LOADING;
                end
                default:              state_d = CFG_EMPTY;
            endcase
        end
    end

    // state outputs
    always_comb begin
        valid = (state_q == CFG_READY);
    end

    // plane storage
    always_ff @(posedge clk) begin
        if (rst) begin
            and_cfg <= '0;
            or_cfg  <= '0;
            rom_cfg <= '0;
            mode    <= MODE_PLA;
            reg_sel <= '0;
        end else if (we) begin
            for (int t = 0; t < N_TERM; t++) begin
                if (int'(addr) == AND_BASE + t) and_cfg[t] <= wdata[2*N_IN-1:0];
            end
            for (int o = 0; o < N_OUT; o++) begin
                if (int'(addr) == OR_BASE + o) or_cfg[o] <= wdata[N_TERM-1:0];
                for (int k = 0; k < CHUNKS; k++) begin
                    if (int'(addr) == ROM_BASE + o*CHUNKS + k)
                        rom_cfg[o][k*DATA_W +: DATA_W] <= wdata;
                end
            end
            if (hit_mode) begin
                if (wdata[1:0] == 2'd1)      mode <= MODE_PAL;
                else if (wdata[1:0] == 2'd2) mode <= MODE_ROM;
                else                         mode <= MODE_PLA;
            end
            if (hit_rsel) reg_sel <= wdata[N_OUT-1:0];
        end
    end

endmodule

// File: rtl/sop_and_plane.sv
module sop_and_plane #(
    parameter int N_IN   = 6,
    parameter int N_TERM = 6
) (
    input  logic [N_IN-1:0]                x,
    input  logic [N_TERM-1:0][2*N_IN-1:0]  and_cfg,
    output logic [N_TERM-1:0]              term
);

    logic [N_TERM-1:0][N_IN-1:0] lit_ok;

    for (genvar t = 0; t < N_TERM; t++) begin : g_term
        for (genvar i = 0; i < N_IN; i++) begin : g_lit
            // bit 2i demands a true literal, bit 2i+1 a complemented one
            assign lit_ok[t][i] = (~and_cfg[t][2*i]   |  x[i]) &
                                  (~and_cfg[t][2*i+1] | ~x[i]);
        end
        assign term[t] = &lit_ok[t];
    end

endmodule

// File: rtl/sop_minterm_dec.sv
module sop_minterm_dec #(
    parameter int N_IN = 6
) (
    input  logic [N_IN-1:0]        x,
    output logic [(1<<N_IN)-1:0]   minterm
);

    for (genvar m = 0; m < (1 << N_IN); m++) begin : g_mt
        assign minterm[m] = (x == N_IN'(m));
    end

endmodule

// File: rtl/sop_or_plane.sv
module sop_or_plane
    import sop_array_pkg::*;
#(
    parameter int N_IN   = 6,
    parameter int N_TERM = 6,
    parameter int N_OUT  = 4
) (
    input  logic [N_TERM-1:0]                term,
    input  logic [(1<<N_IN)-1:0]             minterm,
    input  logic [N_OUT-1:0][N_TERM-1:0]     or_cfg,
    input  logic [N_OUT-1:0][(1<<N_IN)-1:0]  rom_cfg,
    input  plane_mode_e                      mode,
    output logic [N_OUT-1:0]                 sum
);

    localparam int GROUP = (N_TERM + N_OUT - 1) / N_OUT;

    logic [N_OUT-1:0][N_TERM-1:0] pal_mask;

    for (genvar o = 0; o < N_OUT; o++) begin : g_grp
        for (genvar t = 0; t < N_TERM; t++) begin : g_bit
            assign pal_mask[o][t] = ((t / GROUP) == o) ? 1'b1 : 1'b0;
        end
    end

    always_comb begin
        for (int o = 0; o < N_OUT; o++) begin
            unique case (mode)
                MODE_PLA: sum[o] = |(term & or_cfg[o]);
                MODE_PAL: sum[o] = |(term & pal_mask[o]);
                MODE_ROM: sum[o] = |(minterm & rom_cfg[o]);
                default:  sum[o] = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/sop_out_stage.sv
module sop_out_stage #(
    parameter int N_OUT = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             valid,
    input  logic [N_OUT-1:0] sum,
    input  logic [N_OUT-1:0] reg_sel,
    output logic [N_OUT-1:0] y
);

    logic [N_OUT-1:0] gated;
    logic [N_OUT-1:0] y_q;

    assign gated = valid ? sum : '0;

    always_ff @(posedge clk) begin
        if (rst) y_q <= '0;
        else     y_q <= gated;
    end

    for (genvar o = 0; o < N_OUT; o++) begin : g_pick
        assign y[o] = valid & (reg_sel[o] ? y_q[o] : gated[o]);
    end

endmodule

// File: rtl/sop_array.sv
module sop_array
    import sop_array_pkg::*;
#(
    parameter int N_IN   = 6,
    parameter int N_TERM = 6,
    parameter int N_OUT  = 4,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [7:0]        cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic [N_IN-1:0]   x_in,
    output logic [N_OUT-1:0]  y_out,
    output logic              cfg_valid
);

    localparam int MINTERMS = 1 << N_IN;

    logic [N_TERM-1:0][2*N_IN-1:0]  and_cfg;
    logic [N_OUT-1:0][N_TERM-1:0]   or_cfg;
    logic [N_OUT-1:0][MINTERMS-1:0] rom_cfg;
    plane_mode_e                    mode;
    logic [N_OUT-1:0]               reg_sel;
    logic [N_TERM-1:0]              term;
    logic [MINTERMS-1:0]            minterm;
    logic [N_OUT-1:0]               sum;

    sop_cfg_regs #(
        .N_IN(N_IN), .N_TERM(N_TERM), .N_OUT(N_OUT), .DATA_W(DATA_W)
    ) u_cfg (
        .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
        .and_cfg(and_cfg), .or_cfg(or_cfg), .rom_cfg(rom_cfg),
        .mode(mode), .reg_sel(reg_sel), .valid(cfg_valid)
    );

    sop_and_plane #(.N_IN(N_IN), .N_TERM(N_TERM)) u_and (
        .x(x_in), .and_cfg(and_cfg), .term(term)
    );

    sop_minterm_dec #(.N_IN(N_IN)) u_dec (
        .x(x_in), .minterm(minterm)
    );

    sop_or_plane #(.N_IN(N_IN), .N_TERM(N_TERM), .N_OUT(N_OUT)) u_or (
        .term(term), .minterm(minterm), .or_cfg(or_cfg), .rom_cfg(rom_cfg),
        .mode(mode), .sum(sum)
    );

    sop_out_stage #(.N_OUT(N_OUT)) u_out (
        .clk(clk), .rst(rst), .valid(cfg_valid), .sum(sum),
        .reg_sel(reg_sel), .y(y_out)
    );

endmodule

// File: rtl/sop_array_chk.sv
module sop_array_chk #(
    parameter int N_IN   = 6,
    parameter int N_TERM = 6,
    parameter int N_OUT  = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             cfg_we,
    input logic [7:0]       cfg_addr,
    input logic [N_IN-1:0]  x_in,
    input logic [N_OUT-1:0] y_out,
    input logic             cfg_valid
);

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (!cfg_valid && y_out == '0)); // R1

    AST_INVALID_QUIET: assert property (@(posedge clk) disable iff (rst)
        !cfg_valid |-> y_out == '0); // R2

    AST_COMMIT_READY: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_addr == 8'hFF) |=> cfg_valid); // R3

    AST_LOAD_DROPS: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && int'(cfg_addr) < N_TERM) |=> !cfg_valid); // R3

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !cfg_we |=> $stable(cfg_valid)); // R10

    AST_UNMAPPED_HOLD: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_addr == 8'hFE) |=> $stable(cfg_valid)); // R10

endmodule

bind sop_array sop_array_chk #(.N_IN(N_IN), .N_TERM(N_TERM), .N_OUT(N_OUT)) u_chk (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .x_in(x_in), .y_out(y_out), .cfg_valid(cfg_valid)
);

// File: tb/tb_sop_array.sv
`timescale 1ns/100ps
module tb_sop_array;

    localparam int N_IN = 6, N_TERM = 6, N_OUT = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_addr = '0;
    logic [15:0] cfg_wdata = '0;
    logic [5:0]  x_in = '0;
    logic [3:0]  y_out;
    logic        cfg_valid;

    int n_cmp = 0;
    int n_bad = 0;

    // model state
    logic [11:0] m_and [N_TERM];
    logic [5:0]  m_or  [N_OUT];
    logic [63:0] m_rom [N_OUT];
    int          m_mode;
    logic [3:0]  m_rsel;
    bit          m_valid;

    always #2.5 clk = ~clk;

    sop_array dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .x_in(x_in), .y_out(y_out), .cfg_valid(cfg_valid)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int t = 0; t < N_TERM; t++) m_and[t] = '0;
        for (int o = 0; o < N_OUT; o++) begin m_or[o] = '0; m_rom[o] = '0; end
        m_mode = 0; m_rsel = '0; m_valid = 0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [15:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        if (a < 8'd6) begin m_and[a] = d[11:0]; m_valid = 0; end
        else if (a >= 8'h40 && a < 8'h44) begin m_or[a-8'h40] = d[5:0]; m_valid = 0; end
        else if (a >= 8'h80 && a < 8'h90) begin
            m_rom[(a-8'h80)/4][((a-8'h80)%4)*16 +: 16] = d; m_valid = 0;
        end
        else if (a == 8'hC0) begin m_mode = (d[1:0] == 2'd3) ? 0 : int'(d[1:0]); m_valid = 0; end
        else if (a == 8'hC1) begin m_rsel = d[3:0]; m_valid = 0; end
        else if (a == 8'hFF) m_valid = 1;
    endtask

    function automatic logic [3:0] exp_y(input logic [5:0] x);
        logic [5:0] tv;
        logic [3:0] r;
        r = '0;
        if (!m_valid) return r;
        for (int t = 0; t < N_TERM; t++) begin
            tv[t] = 1'b1;
            for (int i = 0; i < N_IN; i++) begin
                case (m_and[t][2*i +: 2])
                    2'b01: if (!x[i]) tv[t] = 1'b0;
                    2'b10: if (x[i])  tv[t] = 1'b0;
                    2'b11: tv[t] = 1'b0;
                    default: ;
                endcase
            end
        end
        for (int o = 0; o < N_OUT; o++) begin
            if (m_mode == 0)      r[o] = |(tv & m_or[o]);
            else if (m_mode == 1) begin
                for (int t = 0; t < N_TERM; t++)
                    if (t / 2 == o && tv[t]) r[o] = 1'b1;
            end
            else                  r[o] = m_rom[o][x];
        end
        return r;
    endfunction

    task automatic sweep(input string tag);
        for (int x = 0; x < 64; x++) begin
            @(negedge clk);
            x_in = 6'(x);
            #1;
            chk(tag, 32'(y_out), 32'(exp_y(6'(x))));
        end
    endtask

    task automatic rand_planes();
        for (int t = 0; t < N_TERM; t++) wr(8'(t), 16'($urandom));
        for (int o = 0; o < N_OUT; o++) wr(8'(8'h40 + o), 16'($urandom));
    endtask

    initial begin
        #500us;
        n_bad++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [5:0] xa, xb;
        logic [3:0] ea, eb;
        void'($urandom(32'd4242));
        model_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R1 valid after reset", 32'(cfg_valid), 32'd0);
        chk("R1 y after reset", 32'(y_out), 32'd0);

        // R1: reset planes behave as zero: commit gives PLA with empty OR plane
        wr(8'hFF, 16'h0);
        #1;
        chk("R3 commit raises valid", 32'(cfg_valid), 32'd1);
        sweep("R1 zero planes");

        // R2/R3: a plane write drops valid and silences outputs
        wr(8'h00, 16'h0000);
        wr(8'h40, 16'h0001);
        #1;
        chk("R3 write drops valid", 32'(cfg_valid), 32'd0);
        for (int x = 0; x < 8; x++) begin
            @(negedge clk); x_in = 6'(x * 7); #1;
            chk("R2 quiet while invalid", 32'(y_out), 32'd0);
        end

        // R10: strobe low with commit address keeps invalid
        @(negedge clk); cfg_addr = 8'hFF; cfg_wdata = '0;
        @(negedge clk); #1;
        chk("R10 no strobe no commit", 32'(cfg_valid), 32'd0);

        // R4 directed: term0 all don't care -> 1; term1 both literals -> 0
        wr(8'h01, 16'h0003);
        wr(8'h41, 16'h0002);
        wr(8'h02, 16'h0009);   // x0 true, x1 complemented
        wr(8'h42, 16'h0004);
        wr(8'hFF, 16'h0);
        sweep("R4 literal encodings");

        // R5: random PLA configurations
        for (int n = 0; n < 10; n++) begin
            rand_planes();
            wr(8'h43, 16'h0000);   // output 3 selects nothing
            wr(8'hC0, 16'h0000);
            wr(8'hFF, 16'h0);
            sweep("R5 PLA random");
        end

        // R6: PAL mode with nonzero OR words present
        for (int n = 0; n < 5; n++) begin
            rand_planes();
            wr(8'hC0, 16'h0001);
            wr(8'hFF, 16'h0);
            sweep("R6 PAL random");
            chk("R6 last output empty", 32'(y_out[3]), 32'd0);
        end

        // R7: ROM mode, AND plane forced false
        for (int t = 0; t < N_TERM; t++) wr(8'(t), 16'hFFFF);
        for (int n = 0; n < 4; n++) begin
            for (int a = 8'h80; a < 8'h90; a++) wr(8'(a), 16'($urandom));
            wr(8'hC0, 16'h0002);
            wr(8'hFF, 16'h0);
            sweep("R7 ROM random");
        end
        // R7 directed: single minterm 63 on output 2
        for (int a = 8'h80; a < 8'h90; a++) wr(8'(a), 16'h0);
        wr(8'h8B, 16'h8000);
        wr(8'hFF, 16'h0);
        sweep("R7 ROM one minterm");

        // R8: mode code 3 acts as PLA
        rand_planes();
        wr(8'hC0, 16'h0003);
        wr(8'hFF, 16'h0);
        sweep("R8 code 3 as PLA");

        // R10: unmapped writes ignored while ready
        wr(8'hFE, 16'hFFFF);
        wr(8'h50, 16'hFFFF);
        wr(8'h3F, 16'hFFFF);
        #1;
        chk("R10 unmapped keeps valid", 32'(cfg_valid), 32'd1);
        sweep("R10 unmapped keeps planes");

        // R9: registered outputs on bits 0 and 2
        wr(8'hC1, 16'h0005);
        wr(8'hFF, 16'h0);
        for (int n = 0; n < 30; n++) begin
            xa = 6'($urandom); xb = 6'($urandom);
            ea = exp_y(xa); eb = exp_y(xb);
            @(negedge clk); x_in = xa;
            @(negedge clk); x_in = xb; #1;
            chk("R9 mixed paths", 32'(y_out), 32'((ea & 4'b0101) | (eb & 4'b1010)));
            @(negedge clk); #1;
            chk("R9 registered settles", 32'(y_out), 32'(eb));
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule